// File: doc/BRIEF.md
# Remote Mailbox Byte-Merge Write Engine

This block takes 64-bit command writes on a small write-only port and turns each one into a read-modify-write of a single 32-bit word in the register space of a chosen core. The command word carries the target core number, a 4-bit byte-keep mask, address bits and 32 bits of new data. One command offset sends into the target's mailbox window. The other sends to any 16-bit register address that the command names.

For each accepted command the engine decodes the target and rejects an unknown core with an error response. It then forms the target address. When any keep bit is set, it reads the old word over a read request/return channel. It merges old and new bytes, issues the write, and returns a one-cycle response. While a command is in flight the command port is not ready, so there is at most one transaction outstanding. A command sent to any other offset is taken and dropped without effect.

Top module: `mbx_write_engine`

## Requirements
- R1: Commands are decoded from `cmdAddr[11:0]`: offset `MAIL_OFS` (default 0x048) is a mailbox send and `ANY_OFS` (default 0x158) is a free-address send. A command at any other offset is accepted and causes no read request, no write and no response, and the port is ready again in the next cycle.
- R2: The target core is `cmdData[25:16]` and drives `rdCore`/`wrCore`. A value of `NUM_CORES` or above produces `respValid`=1 with `respErr`=1 in the cycle after acceptance, with no read request and no write.
- R3: For a mailbox send the target address is `MAILBOX_BASE + 0x20 + (cmdData & 0x1C)`, computed in 16 bits.
- R4: For a free-address send the target address is `cmdData[15:0]`.
- R5: `cmdData[30:27]` is a keep mask in which bit 27+i covers byte i (bits 8i+7:8i, little-endian). A set bit keeps that byte from the word read back. A clear bit takes byte i of `cmdData[63:32]`.
- R6: When all four keep bits are zero, no read is issued and `cmdData[63:32]` is written whole.
- R7: `cmdReady` is high only when idle. It is low from the cycle after a valid target command is accepted until its response cycle has passed.
- R8: `rdValid` stays high with stable `rdCore`/`rdAddr` until `rdReady`. The engine then waits for `rdDataValid` and uses `rdData` only in that cycle.
- R9: `wrValid` stays high with stable `wrCore`/`wrAddr`/`wrData` until `wrReady`. `respValid` is high for exactly one cycle, with `respErr`=0, in the cycle after the write handshake.
- R10: After reset `cmdReady`=1 and `rdValid`, `wrValid` and `respValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command write strobe |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdAddr | input | 12 | Command offset |
| cmdData | input | 64 | Command word |
| rdValid | output | 1 | Read request to target |
| rdReady | input | 1 | Read request accepted |
| rdCore | output | CORE_W | Target core of read |
| rdAddr | output | 16 | Target address of read |
| rdDataValid | input | 1 | Read data return strobe |
| rdData | input | 32 | Returned old word |
| wrValid | output | 1 | Write request to target |
| wrReady | input | 1 | Write accepted |
| wrCore | output | CORE_W | Target core of write |
| wrAddr | output | 16 | Target address of write |
| wrData | output | 32 | Merged word |
| respValid | output | 1 | Command response strobe |
| respErr | output | 1 | 1 = decode error, 0 = OK |

## Verification
The assertions assume that the target side returns exactly one `rdDataValid` beat after each read handshake and never raises it at any other time. They also assume that `cmdValid` is only meaningful while `cmdReady` is high. The stimulus keeps to this by running one command at a time. Each read is answered only after its handshake, with random stall cycles on `rdReady`, `rdDataValid` and `wrReady`. `rdData` carries random junk outside its valid cycle, so a capture at the wrong moment shows up in the merged write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int CMD_W    = 64;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 16;
  localparam int OFS_W    = 12;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 10;
  localparam int MASK_LSB = 27;
  localparam int BYTES    = WORD_W / 8;
  localparam int DATA_LSB = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_READ,
    ST_WRITE,
    ST_RESP
  } mbxState_t;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_MAIL,
    KIND_ANY
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic mergeRd;
  } dpStrobe_t;

  // decode results from datapath to control
  typedef struct packed {
    cmdKind_t kind;
    logic     coreOk;
    logic     maskZero;
  } dpStatus_t;

endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int                NUM_CORES    = 4,
  parameter logic [ADDR_W-1:0] MAILBOX_BASE = 16'h1000,
  parameter logic [OFS_W-1:0]  MAIL_OFS     = 12'h048,
  parameter logic [OFS_W-1:0]  ANY_OFS      = 12'h158,
  localparam int               CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFS_W-1:0]  cmdAddr,
  input  logic [CMD_W-1:0]  cmdData,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] rdData,
  output dpStatus_t         status,
  output logic [CORE_W-1:0] tgtCore,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [WORD_W-1:0] wrWord
);

  localparam logic [ADDR_W-1:0] MBX_WIN = 16'h0020;

  logic [ID_W-1:0]   idRaw;
  logic [BYTES-1:0]  maskIn;
  logic [WORD_W-1:0] newIn;
  logic [ADDR_W-1:0] addrIn;
  logic [BYTES-1:0]  maskReg;
  logic [WORD_W-1:0] mergedWord;
  logic              unusedCmdBits;

  assign idRaw  = cmdData[ID_LSB +: ID_W];
  assign maskIn = cmdData[MASK_LSB +: BYTES];
  assign newIn  = cmdData[DATA_LSB +: WORD_W];
  assign unusedCmdBits = ^{cmdData[31], cmdData[26]};

  always_comb begin
    if (cmdAddr == MAIL_OFS)     status.kind = KIND_MAIL;
    else if (cmdAddr == ANY_OFS) status.kind = KIND_ANY;
    else                         status.kind = KIND_NONE;
  end

  assign status.coreOk   = 32'(idRaw) < 32'(NUM_CORES);
  assign status.maskZero = (maskIn == '0);

  always_comb begin
    if (status.kind == KIND_MAIL)
      addrIn = MAILBOX_BASE + MBX_WIN + {{(ADDR_W-5){1'b0}}, cmdData[4:2], 2'b00};
    else
      addrIn = cmdData[ADDR_W-1:0];
  end

  // per-byte select between the old word and the new data
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign mergedWord[b*8 +: 8] = maskReg[b] ? rdData[b*8 +: 8] : wrWord[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtCore <= '0;
      tgtAddr <= '0;
      maskReg <= '0;
      wrWord  <= '0;
    end else if (strobe.capture) begin
      tgtCore <= idRaw[CORE_W-1:0];
      tgtAddr <= addrIn;
      maskReg <= maskIn;
      wrWord  <= newIn;
    end else if (strobe.mergeRd) begin
      wrWord  <= mergedWord;
    end
  end

  // a read merge only ever follows a command that had keep bits set
  AST_MERGE_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mergeRd |-> (maskReg != '0)); // R6

endmodule

// File: rtl/mbx_control.sv
module mbx_control
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  dpStatus_t status,
  input  logic      rdReady,
  input  logic      rdDataValid,
  input  logic      wrReady,
  output dpStrobe_t strobe,
  output logic      cmdReady,
  output logic      rdValid,
  output logic      wrValid,
  output logic      respValid,
  output logic      respErr
);

  mbxState_t state, stateNext;
  logic      accept;
  logic      errReg;

  assign cmdReady  = (state == ST_IDLE);
  assign accept    = cmdValid && cmdReady;
  assign rdValid   = (state == ST_READ);
  assign wrValid   = (state == ST_WRITE);
  assign respValid = (state == ST_RESP);
  assign respErr   = errReg;

  assign strobe.capture = accept;
  assign strobe.mergeRd = (state == ST_WAIT_READ) && rdDataValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (accept && status.kind != KIND_NONE) begin
          if (!status.coreOk)       stateNext = ST_RESP;
          else if (status.maskZero) stateNext = ST_WRITE;
          else                      stateNext = ST_READ;
        end
      end
      ST_READ:      if (rdReady)     stateNext = ST_WAIT_READ;
      ST_WAIT_READ: if (rdDataValid) stateNext = ST_WRITE;
      ST_WRITE:     if (wrReady)     stateNext = ST_RESP;
      ST_RESP:                       stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept && status.kind != KIND_NONE) errReg <= !status.coreOk;
    end
  end

  AST_IGNORED_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (accept && status.kind == KIND_NONE) |=> (cmdReady && !respValid)); // R1
  AST_BAD_CORE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && status.kind != KIND_NONE && !status.coreOk) |=> (respValid && respErr)); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (accept && status.kind != KIND_NONE) |=> !cmdReady); // R7
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrValid, respValid, cmdReady})); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> rdValid); // R8
  AST_WR_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> (respValid && !respErr)); // R9
  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R9

endmodule

// File: rtl/mbx_write_engine.sv
module mbx_write_engine
  import mbx_pkg::*;
#(
  parameter int                NUM_CORES    = 4,
  parameter logic [ADDR_W-1:0] MAILBOX_BASE = 16'h1000,
  parameter logic [OFS_W-1:0]  MAIL_OFS     = 12'h048,
  parameter logic [OFS_W-1:0]  ANY_OFS      = 12'h158,
  localparam int               CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [11:0]       cmdAddr,
  input  logic [63:0]       cmdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [CORE_W-1:0] rdCore,
  output logic [15:0]       rdAddr,
  input  logic              rdDataValid,
  input  logic [31:0]       rdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [CORE_W-1:0] wrCore,
  output logic [15:0]       wrAddr,
  output logic [31:0]       wrData,
  output logic              respValid,
  output logic              respErr
);

  dpStrobe_t         strobe;
  dpStatus_t         status;
  logic [CORE_W-1:0] tgtCore;
  logic [ADDR_W-1:0] tgtAddr;

  mbx_datapath #(
    .NUM_CORES    (NUM_CORES),
    .MAILBOX_BASE (MAILBOX_BASE),
    .MAIL_OFS     (MAIL_OFS),
    .ANY_OFS      (ANY_OFS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .strobe  (strobe),
    .rdData  (rdData),
    .status  (status),
    .tgtCore (tgtCore),
    .tgtAddr (tgtAddr),
    .wrWord  (wrData)
  );

  mbx_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .status      (status),
    .rdReady     (rdReady),
    .rdDataValid (rdDataValid),
    .wrReady     (wrReady),
    .strobe      (strobe),
    .cmdReady    (cmdReady),
    .rdValid     (rdValid),
    .wrValid     (wrValid),
    .respValid   (respValid),
    .respErr     (respErr)
  );

  assign rdCore = tgtCore;
  assign rdAddr = tgtAddr;
  assign wrCore = tgtCore;
  assign wrAddr = tgtAddr;

  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> ($stable(rdAddr) && $stable(rdCore))); // R8
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrData) && $stable(wrAddr) && $stable(wrCore))); // R9

endmodule

// File: tb/mbx_write_engine_tb.sv
module mbx_write_engine_tb;

  localparam int          NC       = 4;
  localparam int          CW       = 2;
  localparam logic [15:0] MBASE    = 16'h1000;
  localparam logic [11:0] OFS_MAIL = 12'h048;
  localparam logic [11:0] OFS_ANY  = 12'h158;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [11:0]   cmdAddr = '0;
  logic [63:0]   cmdData = '0;
  logic          rdValid;
  logic          rdReady = 1'b0;
  logic [CW-1:0] rdCore;
  logic [15:0]   rdAddr;
  logic          rdDataValid = 1'b0;
  logic [31:0]   rdData = '0;
  logic          wrValid;
  logic          wrReady = 1'b0;
  logic [CW-1:0] wrCore;
  logic [15:0]   wrAddr;
  logic [31:0]   wrData;
  logic          respValid;
  logic          respErr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic [31:0] mem [NC][64];

  always #2 clk = ~clk;

  mbx_write_engine #(
    .NUM_CORES(NC), .MAILBOX_BASE(MBASE), .MAIL_OFS(OFS_MAIL), .ANY_OFS(OFS_ANY)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdValid(rdValid), .rdReady(rdReady),
    .rdCore(rdCore), .rdAddr(rdAddr), .rdDataValid(rdDataValid), .rdData(rdData),
    .wrValid(wrValid), .wrReady(wrReady), .wrCore(wrCore), .wrAddr(wrAddr),
    .wrData(wrData), .respValid(respValid), .respErr(respErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expAddr(input logic [11:0] ofs, input logic [63:0] c);
    if (ofs == OFS_MAIL) return MBASE + 16'h20 + (c[15:0] & 16'h001C);
    return c[15:0];
  endfunction

  function automatic logic [31:0] mergeWord(input logic [31:0] old,
                                            input logic [31:0] nw, input logic [3:0] keep);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = keep[b] ? old[b*8 +: 8] : nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mkCmd(input logic [31:0] nw, input logic [3:0] keep,
                                        input logic [9:0] id, input logic [15:0] lo,
                                        input logic [1:0] junk);
    return {nw, junk[1], keep, junk[0], id, lo};
  endfunction

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdData = $urandom;
    end
  endtask

  task automatic runCmd(input logic [11:0] ofs, input logic [63:0] c);
    logic [9:0]  id;
    logic [3:0]  keep;
    logic [15:0] ad;
    logic [31:0] old;
    logic [31:0] expW;
    string       aTag;
    id   = c[25:16];
    keep = c[30:27];
    ad   = expAddr(ofs, c);
    aTag = (ofs == OFS_MAIL) ? "R3" : "R4";
    old  = '0;
    @(negedge clk);
    chk("R7", "ready before command", cmdReady, 1);
    cmdValid = 1'b1; cmdAddr = ofs; cmdData = c;
    @(negedge clk);
    cmdValid = 1'b0; cmdData = {$urandom, $urandom};
    if (ofs != OFS_MAIL && ofs != OFS_ANY) begin
      for (int i = 0; i < 3; i++) begin
        chk("R1", "ignored offset activity",
            {61'b0, rdValid, wrValid, respValid}, 64'd0);
        chk("R1", "ignored offset ready", cmdReady, 1);
        @(negedge clk);
      end
    end else if (id >= NC) begin
      chk("R2", "error response", {62'b0, respValid, respErr}, 64'd3);
      chk("R2", "no access on error", {62'b0, rdValid, wrValid}, 64'd0);
      chk("R7", "busy in error response", cmdReady, 0);
      @(negedge clk);
      chk("R2", "response single cycle", respValid, 0);
      chk("R7", "ready after error", cmdReady, 1);
    end else begin
      if (keep != 4'd0) begin
        chk("R8", "read requested", rdValid, 1);
        chk("R7", "busy during read", cmdReady, 0);
        chk(aTag, "read address", rdAddr, ad);
        chk("R2", "read core", rdCore, id[CW-1:0]);
        for (int s = 0; s < int'($urandom % 3); s++) begin
          @(negedge clk);
          chk("R8", "read held", {rdValid, rdAddr}, {1'b1, ad});
        end
        rdReady = 1'b1;
        @(negedge clk);
        rdReady = 1'b0;
        chk("R8", "read dropped after handshake", {62'b0, rdValid, wrValid}, 64'd0);
        for (int s = 0; s < int'($urandom % 3); s++) begin
          rdData = $urandom;
          @(negedge clk);
          chk("R8", "wait for read data", wrValid, 0);
        end
        old = mem[id[CW-1:0]][ad[7:2]];
        rdDataValid = 1'b1; rdData = old;
        @(negedge clk);
        rdDataValid = 1'b0; rdData = $urandom;
      end else begin
        chk("R6", "no read when keep mask zero", rdValid, 0);
      end
      expW = mergeWord(old, c[63:32], keep);
      chk((keep == 0) ? "R6" : "R9", "write requested", wrValid, 1);
      chk(aTag, "write address", wrAddr, ad);
      chk("R2", "write core", wrCore, id[CW-1:0]);
      chk((keep == 0) ? "R6" : "R5", "merged data", wrData, expW);
      for (int s = 0; s < int'($urandom % 3); s++) begin
        @(negedge clk);
        rdData = $urandom;
        chk("R9", "write held", {wrValid, wrData}, {1'b1, expW});
      end
      wrReady = 1'b1;
      @(negedge clk);
      wrReady = 1'b0;
      mem[id[CW-1:0]][ad[7:2]] = expW;
      chk("R9", "ok response", {61'b0, respValid, respErr, wrValid}, 64'd4);
      @(negedge clk);
      chk("R9", "response single cycle", respValid, 0);
      chk("R7", "ready after response", cmdReady, 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seedInit;
    logic [11:0] ofs;
    logic [9:0]  id;
    seedInit = $urandom(32'd20240611);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 64; w++)
        mem[c][w] = {8'(c), 8'(w), 16'hA5C3} ^ 32'h3C00_0F00;
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {60'b0, cmdReady, rdValid, wrValid, respValid}, 64'd8);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", {60'b0, cmdReady, rdValid, wrValid, respValid}, 64'd8);

    // directed corner cases
    runCmd(OFS_MAIL, mkCmd(32'hDEAD_BEEF, 4'h0, 10'd1, 16'h0014, 2'b11)); // R6 whole word
    runCmd(OFS_MAIL, mkCmd(32'h1122_3344, 4'hF, 10'd1, 16'h0014, 2'b00)); // R5 keep all
    runCmd(OFS_MAIL, mkCmd(32'hAABB_CCDD, 4'h5, 10'd2, 16'hFFFC, 2'b10)); // R3 top slot
    runCmd(OFS_ANY,  mkCmd(32'h0F0F_F0F0, 4'hA, 10'd3, 16'h2468, 2'b01)); // R4
    runCmd(OFS_ANY,  mkCmd(32'h5555_AAAA, 4'h1, 10'd0, 16'h00FC, 2'b00)); // R5 byte 0
    runCmd(OFS_ANY,  mkCmd(32'h1234_5678, 4'h8, 10'd4, 16'h0010, 2'b00)); // R2 first bad id
    runCmd(OFS_MAIL, mkCmd(32'h1234_5678, 4'h0, 10'd1023, 16'h0, 2'b00)); // R2 max id
    runCmd(12'h000,  mkCmd(32'hFFFF_FFFF, 4'h0, 10'd1, 16'h0014, 2'b00)); // R1
    runCmd(OFS_MAIL ^ 12'h800, mkCmd(32'h0, 4'h3, 10'd0, 16'h0, 2'b00));  // R1 near miss

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      case ($urandom % 8)
        0, 1, 2, 3: ofs = OFS_MAIL;
        4, 5, 6:    ofs = OFS_ANY;
        default: begin
          ofs = 12'($urandom);
          if (ofs == OFS_MAIL || ofs == OFS_ANY) ofs = 12'h7FF;
        end
      endcase
      id = (($urandom % 8) < 6) ? 10'($urandom % NC) : 10'(NC + ($urandom % (1024 - NC)));
      runCmd(ofs, mkCmd($urandom, 4'($urandom), id, 16'($urandom), 2'($urandom)));
      if (($urandom % 4) == 0) idleCycles(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule